// File: doc/BRIEF.md
# Address Translation Cache with Large-Page Entries

This block holds recently used virtual-to-physical translations so that a memory access can skip the multi-level table walk. Sixteen fully associative entries each hold a virtual page number, a physical frame number, three permission bits and a size flag. The size flag marks the entry as a small page (4 KiB) or a large page (2 MiB). A large entry ignores the bottom nine bits of the page number, so one entry covers a region that would otherwise need 512 small entries.

The lookup side is a valid/ready stream. A request is accepted when `lk_valid` and `lk_ready` are both high. The result appears in a one-deep response register that is also valid/ready. `lk_ready` is high whenever that register is empty or is being drained in the same cycle. While `rsp_ready` is low, a pending response stays frozen and no new lookup is accepted. A miss tells the surrounding logic to start a table walk. When the walk finishes, the walker installs the translation through the fill stream. Plain control inputs remove the entries covering one address, or remove every entry at once.

A fill first looks for any valid entry whose range overlaps the new page and rewrites it, so the table never holds two entries that overlap. If there is no such entry, the fill takes the lowest-numbered invalid entry. If the table is full, a round-robin pointer picks the victim. The pointer starts at entry 0 after reset and moves on only when it has been used.

Top module: `xlat_cache_top`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` is 0, and `lk_ready` and `fill_ready` are 1.
- R2: A lookup that hits a small entry returns `rsp_hit`=1, `rsp_paddr` = {frame from `fill_paddr[PA_W-1:12]`, `lk_vaddr[11:0]`}, and the stored permission bits on `rsp_perm`. The permission bits are [0]=write, [1]=execute, [2]=user. The response is valid on the edge after acceptance.
- R3: A lookup that matches no valid entry returns `rsp_hit`=0, `rsp_paddr`=0 and `rsp_perm`=0.
- R4: A large entry (`fill_huge`=1) matches any address whose bits [VA_W-1:21] equal those of its fill address. It returns `rsp_paddr` = {`fill_paddr[PA_W-1:21]`, `lk_vaddr[20:0]`}.
- R5: `lk_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid` is 1 and `rsp_ready` is 0, the response outputs hold their values.
- R6: When no entry overlaps the fill, the fill takes the lowest invalid entry. With all 16 entries valid, victims are taken round-robin from entry 0 upward, so the 17th and 18th distinct fills after a flush evict the 1st and 2nd pages filled.
- R7: Refilling a page that is already cached rewrites that entry with the new frame and uses no extra entry.
- R8: A fill replaces every valid entry whose range overlaps the new range. For example, a large fill absorbs the small entries inside its region. Those entries become free.
- R9: `inv_page` invalidates, on the next edge, every entry whose own range covers `inv_vaddr`, whatever its size. Other entries are untouched.
- R10: `inv_all` invalidates all entries on the next edge.
- R11: While `inv_page` or `inv_all` is high, `fill_ready` is 0 and a presented fill is not installed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this cycle if valid |
| lk_vaddr | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | 1 on hit, 0 on miss (start a walk) |
| rsp_paddr | output | PA_W | Translated physical address, 0 on miss |
| rsp_perm | output | 3 | Permissions [0]=write [1]=execute [2]=user |
| fill_valid | input | 1 | Fill request valid |
| fill_ready | output | 1 | Fill accepted this cycle if valid |
| fill_vaddr | input | VA_W | Virtual address of the page being installed |
| fill_paddr | input | PA_W | Physical base of the page |
| fill_huge | input | 1 | 1 = 2 MiB page, 0 = 4 KiB page |
| fill_perm | input | 3 | Permission bits to store |
| inv_page | input | 1 | Invalidate entries covering `inv_vaddr` |
| inv_all | input | 1 | Invalidate every entry |
| inv_vaddr | input | VA_W | Address for single-page invalidation |

## Verification
Each result is due a fixed number of edges after its stimulus. A response becomes valid on the first rising edge after a lookup is accepted. A fill or invalidation changes the table on the edge that accepts it, so a lookup accepted on the next edge already sees the change. The bench drives every input on the falling edge and samples the response outputs on the following falling edge, half a period after the edge that produced them. In the back-pressure case the bench samples again after extra stalled edges to confirm that nothing moved.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
  localparam int unsigned SMALL_SHIFT = 12;
  localparam int unsigned HUGE_SHIFT  = 21;
  localparam int unsigned SPAN_BITS   = HUGE_SHIFT - SMALL_SHIFT;
  localparam int unsigned PERM_W      = 3;

  typedef struct packed {
    logic user;
    logic exec;
    logic write;
  } perm_t;
endpackage

// File: rtl/xlat_match.sv
`timescale 1ns/1ps
module xlat_match
  import xlat_pkg::*;
#(
  parameter int unsigned VPN_W = 36
) (
  input  logic             ent_valid,
  input  logic             ent_huge,
  input  logic [VPN_W-1:0] ent_vpn,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic             fill_huge,
  output logic             lk_hit,
  output logic             inv_hit,
  output logic             fill_ovl
);
  logic lk_hi_eq, inv_hi_eq, fill_hi_eq;
  logic lk_lo_eq, inv_lo_eq, fill_lo_eq;

  always_comb begin
    lk_hi_eq   = ent_vpn[VPN_W-1:SPAN_BITS] == lk_vpn[VPN_W-1:SPAN_BITS];
    inv_hi_eq  = ent_vpn[VPN_W-1:SPAN_BITS] == inv_vpn[VPN_W-1:SPAN_BITS];
    fill_hi_eq = ent_vpn[VPN_W-1:SPAN_BITS] == fill_vpn[VPN_W-1:SPAN_BITS];
    lk_lo_eq   = ent_vpn[SPAN_BITS-1:0] == lk_vpn[SPAN_BITS-1:0];
    inv_lo_eq  = ent_vpn[SPAN_BITS-1:0] == inv_vpn[SPAN_BITS-1:0];
    fill_lo_eq = ent_vpn[SPAN_BITS-1:0] == fill_vpn[SPAN_BITS-1:0];
    // an entry's own size decides how much of the address it covers
    lk_hit   = ent_valid && lk_hi_eq  && (ent_huge || lk_lo_eq);
    inv_hit  = ent_valid && inv_hi_eq && (ent_huge || inv_lo_eq);
    // two ranges overlap when they agree at the coarser of the two sizes
    fill_ovl = ent_valid && fill_hi_eq && (ent_huge || fill_huge || fill_lo_eq);
  end
endmodule

// File: rtl/xlat_victim.sv
`timescale 1ns/1ps
module xlat_victim #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] ovl_vec,
  input  logic               alloc,
  output logic [IDX_W-1:0]   pick_idx
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] ovl_idx, free_idx;
  logic             any_ovl, any_free, use_rr;

  always_comb begin
    any_ovl  = |ovl_vec;
    any_free = ~&valid_vec;
    ovl_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ovl_vec[i])    ovl_idx  = IDX_W'(i);
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
    use_rr   = !any_ovl && !any_free;
    pick_idx = any_ovl ? ovl_idx : (any_free ? free_idx : rr_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (alloc && use_rr) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  // R6: a free slot is never skipped in favour of evicting a live one
  assert_free_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !any_ovl && any_free) |-> !valid_vec[pick_idx]);
endmodule

// File: rtl/xlat_store.sv
`timescale 1ns/1ps
module xlat_store #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 36,
  parameter int unsigned PFN_W   = 28,
  parameter int unsigned PERM_W  = 3,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          inv_en,
  input  logic [ENTRIES-1:0]            inv_vec,
  input  logic                          fill_en,
  input  logic [IDX_W-1:0]              fill_idx,
  input  logic [ENTRIES-1:0]            fill_ovl_vec,
  input  logic [VPN_W-1:0]              fill_vpn,
  input  logic [PFN_W-1:0]              fill_pfn,
  input  logic                          fill_huge,
  input  logic [PERM_W-1:0]             fill_perm,
  output logic [ENTRIES-1:0]            valid_vec,
  output logic [ENTRIES-1:0]            huge_vec,
  output logic [ENTRIES-1:0][VPN_W-1:0] vpn_arr,
  output logic [ENTRIES-1:0][PFN_W-1:0] pfn_arr,
  output logic [ENTRIES-1:0][PERM_W-1:0] perm_arr
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = fill_en && (fill_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_vec[g] <= 1'b0;
      end else if (flush) begin
        valid_vec[g] <= 1'b0;
      end else if (inv_en && inv_vec[g]) begin
        valid_vec[g] <= 1'b0;
      end else if (sel) begin
        valid_vec[g] <= 1'b1;
      end else if (fill_en && fill_ovl_vec[g]) begin
        valid_vec[g] <= 1'b0;  // absorbed by the new, wider entry
      end
    end

    always_ff @(posedge clk) begin
      if (sel && !flush && !inv_en) begin
        huge_vec[g] <= fill_huge;
        vpn_arr[g]  <= fill_vpn;
        pfn_arr[g]  <= fill_pfn;
        perm_arr[g] <= fill_perm;
      end
    end
  end

  // R10: flush empties the table in one edge
  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));
  // R9: every covering entry is gone after a page invalidation
  assert_inv_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !flush) |=> ((valid_vec & $past(inv_vec)) == '0));
  // R7: the chosen slot holds a live entry after a fill
  assert_fill_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush && !inv_en) |=> valid_vec[$past(fill_idx)]);
endmodule

// File: rtl/xlat_cache_top.sv
`timescale 1ns/1ps
module xlat_cache_top
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VA_W    = 48,
  parameter int unsigned PA_W    = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  output logic            lk_ready,
  input  logic [VA_W-1:0] lk_vaddr,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_hit,
  output logic [PA_W-1:0] rsp_paddr,
  output logic [2:0]      rsp_perm,
  input  logic            fill_valid,
  output logic            fill_ready,
  input  logic [VA_W-1:0] fill_vaddr,
  input  logic [PA_W-1:0] fill_paddr,
  input  logic            fill_huge,
  input  logic [2:0]      fill_perm,
  input  logic            inv_page,
  input  logic            inv_all,
  input  logic [VA_W-1:0] inv_vaddr
);
  localparam int unsigned VPN_W = VA_W - SMALL_SHIFT;
  localparam int unsigned PFN_W = PA_W - SMALL_SHIFT;
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             valid_vec, huge_vec;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_arr;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_arr;
  logic [ENTRIES-1:0][PERM_W-1:0] perm_arr;
  logic [ENTRIES-1:0]             lk_hit_vec, inv_hit_vec, fill_ovl_vec;
  logic [IDX_W-1:0]               pick_idx;
  logic                           fill_fire, lk_fire;

  assign fill_ready = !(inv_page || inv_all);
  assign fill_fire  = fill_valid && fill_ready;
  assign lk_ready   = !rsp_valid || rsp_ready;
  assign lk_fire    = lk_valid && lk_ready;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    xlat_match #(.VPN_W(VPN_W)) u_match (
      .ent_valid (valid_vec[g]),
      .ent_huge  (huge_vec[g]),
      .ent_vpn   (vpn_arr[g]),
      .lk_vpn    (lk_vaddr[VA_W-1:SMALL_SHIFT]),
      .inv_vpn   (inv_vaddr[VA_W-1:SMALL_SHIFT]),
      .fill_vpn  (fill_vaddr[VA_W-1:SMALL_SHIFT]),
      .fill_huge (fill_huge),
      .lk_hit    (lk_hit_vec[g]),
      .inv_hit   (inv_hit_vec[g]),
      .fill_ovl  (fill_ovl_vec[g])
    );
  end

  xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_vec),
    .ovl_vec   (fill_ovl_vec),
    .alloc     (fill_fire),
    .pick_idx  (pick_idx)
  );

  xlat_store #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W),
    .PERM_W  (PERM_W)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (inv_all),
    .inv_en       (inv_page),
    .inv_vec      (inv_hit_vec),
    .fill_en      (fill_fire),
    .fill_idx     (pick_idx),
    .fill_ovl_vec (fill_ovl_vec),
    .fill_vpn     (fill_vaddr[VA_W-1:SMALL_SHIFT]),
    .fill_pfn     (fill_paddr[PA_W-1:SMALL_SHIFT]),
    .fill_huge    (fill_huge),
    .fill_perm    (fill_perm),
    .valid_vec    (valid_vec),
    .huge_vec     (huge_vec),
    .vpn_arr      (vpn_arr),
    .pfn_arr      (pfn_arr),
    .perm_arr     (perm_arr)
  );

  // select the single matching entry (at most one by construction of fills)
  logic [PFN_W-1:0] sel_pfn;
  perm_t            sel_perm;
  logic             sel_huge, any_hit;
  logic [PA_W-1:0]  hit_pa;

  always_comb begin
    sel_pfn  = '0;
    sel_perm = '0;
    sel_huge = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hit_vec[i]) begin
        sel_pfn  = sel_pfn | pfn_arr[i];
        sel_perm = sel_perm | perm_t'(perm_arr[i]);
        sel_huge = sel_huge | huge_vec[i];
      end
    end
    any_hit = |lk_hit_vec;
    if (sel_huge)
      hit_pa = {sel_pfn[PFN_W-1:SPAN_BITS], lk_vaddr[HUGE_SHIFT-1:0]};
    else
      hit_pa = {sel_pfn, lk_vaddr[SMALL_SHIFT-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
    end else if (lk_fire) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= any_hit;
      rsp_paddr <= any_hit ? hit_pa : '0;
      rsp_perm  <= any_hit ? sel_perm : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R7/R8: the table never holds two entries covering one address
  assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lk_hit_vec) <= 1);
  // R5: a stalled response does not move
  assert_rsp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_paddr)
                                   && $stable(rsp_perm)));
  // R3: a miss carries no address or rights
  assert_miss_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && rsp_perm == '0));
endmodule

// File: tb/sim_xlat_cache_top.sv
`timescale 1ns/1ps
module sim_xlat_cache_top;
  localparam int VA_W = 48;
  localparam int PA_W = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, rsp_ready = 1, fill_valid = 0, fill_huge = 0;
  logic inv_page = 0, inv_all = 0;
  logic [VA_W-1:0] lk_vaddr = '0, fill_vaddr = '0, inv_vaddr = '0;
  logic [PA_W-1:0] fill_paddr = '0;
  logic [2:0] fill_perm = '0;
  logic lk_ready, rsp_valid, rsp_hit, fill_ready;
  logic [PA_W-1:0] rsp_paddr;
  logic [2:0] rsp_perm;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic            g_hit;
  logic [PA_W-1:0] g_pa;
  logic [2:0]      g_perm;

  always #2.5 clk = ~clk;

  xlat_cache_top u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vaddr(fill_vaddr),
    .fill_paddr(fill_paddr), .fill_huge(fill_huge), .fill_perm(fill_perm),
    .inv_page(inv_page), .inv_all(inv_all), .inv_vaddr(inv_vaddr)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d cycles expected=finished", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_fill(input logic [VA_W-1:0] va, input logic [PA_W-1:0] pa,
                         input logic huge, input logic [2:0] perm);
    @(negedge clk);
    fill_valid = 1; fill_vaddr = va; fill_paddr = pa; fill_huge = huge; fill_perm = perm;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_lookup(input logic [VA_W-1:0] va);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va; rsp_ready = 1;
    @(negedge clk);
    lk_valid = 0;
    g_hit = rsp_hit; g_pa = rsp_paddr; g_perm = rsp_perm;
  endtask

  task automatic do_flush();
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
  endtask

  function automatic logic [VA_W-1:0] pg(input int n);
    return 48'h1000_0000_0000 + (VA_W'(n) << 12);
  endfunction

  task automatic t_reset();
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 lk_ready", 64'(lk_ready), 64'd1);
    chk("R1 fill_ready", 64'(fill_ready), 64'd1);
    do_lookup(48'h7ffe_1234_5678);
    chk("R1 empty miss", 64'(g_hit), 64'd0);
  endtask

  task automatic t_small();
    do_fill(48'h7ffe_1234_5678, 40'h00_1234_5000, 0, 3'b101);
    do_lookup(48'h7ffe_1234_5abc);
    chk("R2 hit", 64'(g_hit), 64'd1);
    chk("R2 paddr", 64'(g_pa), 64'h00_1234_5abc);
    chk("R2 perm", 64'(g_perm), 64'd5);
    do_lookup(48'h7ffe_1234_6000);
    chk("R3 miss hit", 64'(g_hit), 64'd0);
    chk("R3 miss paddr", 64'(g_pa), 64'd0);
    chk("R3 miss perm", 64'(g_perm), 64'd0);
  endtask

  task automatic t_huge();
    do_flush();
    do_fill(48'h0000_4020_0000, 40'h12_3440_0000, 1, 3'b011);
    do_lookup(48'h0000_403f_f123);
    chk("R4 hit", 64'(g_hit), 64'd1);
    chk("R4 paddr", 64'(g_pa), 64'h12_345f_f123);
    chk("R4 perm", 64'(g_perm), 64'd3);
    do_lookup(48'h0000_4040_0000);
    chk("R4 next region miss", 64'(g_hit), 64'd0);
  endtask

  task automatic t_backpressure();
    logic [PA_W-1:0] held;
    @(negedge clk);
    lk_valid = 1; lk_vaddr = 48'h0000_4020_0010; rsp_ready = 0;
    @(negedge clk);
    chk("R5 rsp_valid", 64'(rsp_valid), 64'd1);
    chk("R5 lk_ready low", 64'(lk_ready), 64'd0);
    held = rsp_paddr;
    lk_vaddr = 48'h0000_4020_0020;
    @(negedge clk); @(negedge clk);
    chk("R5 held paddr", 64'(rsp_paddr), 64'(held));
    chk("R5 held paddr value", 64'(held), 64'h12_3440_0010);
    lk_valid = 0; rsp_ready = 1;
    @(negedge clk);
    chk("R5 drained", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_inv_page();
    do_flush();
    do_fill(pg(1), 40'h00_0000_1000, 0, 3'b001);
    do_fill(pg(2), 40'h00_0000_2000, 0, 3'b001);
    do_fill(48'h0000_0060_0000, 40'h00_0060_0000, 1, 3'b001);
    @(negedge clk); inv_page = 1; inv_vaddr = 48'h0000_0071_2345;
    @(negedge clk); inv_page = 0;
    do_lookup(48'h0000_0060_0000);
    chk("R9 large entry removed", 64'(g_hit), 64'd0);
    do_lookup(pg(1));
    chk("R9 other kept", 64'(g_hit), 64'd1);
    @(negedge clk); inv_page = 1; inv_vaddr = pg(1) + 48'h123;
    @(negedge clk); inv_page = 0;
    do_lookup(pg(1));
    chk("R9 small entry removed", 64'(g_hit), 64'd0);
    do_lookup(pg(2));
    chk("R9 neighbour kept", 64'(g_pa), 64'h00_0000_2000);
  endtask

  task automatic t_flush();
    do_fill(pg(3), 40'h00_0000_3000, 0, 3'b000);
    do_flush();
    do_lookup(pg(2));
    chk("R10 flushed a", 64'(g_hit), 64'd0);
    do_lookup(pg(3));
    chk("R10 flushed b", 64'(g_hit), 64'd0);
  endtask

  task automatic t_inv_blocks_fill();
    @(negedge clk);
    inv_page = 1; inv_vaddr = pg(99);
    fill_valid = 1; fill_vaddr = pg(7); fill_paddr = 40'h00_0000_7000; fill_huge = 0;
    #1;
    chk("R11 fill_ready low", 64'(fill_ready), 64'd0);
    @(negedge clk);
    inv_page = 0; fill_valid = 0;
    do_lookup(pg(7));
    chk("R11 fill dropped", 64'(g_hit), 64'd0);
  endtask

  task automatic t_refill();
    do_flush();
    do_fill(pg(0), 40'h00_0aaa_0000, 0, 3'b001);
    do_fill(pg(0) + 48'h80, 40'h00_0bbb_0000, 0, 3'b111);
    for (int i = 1; i < 16; i++) do_fill(pg(i), PA_W'(i) << 12, 0, 3'b000);
    do_lookup(pg(0) + 48'h4);
    chk("R7 updated frame", 64'(g_pa), 64'h00_0bbb_0004);
    chk("R7 updated perm", 64'(g_perm), 64'd7);
    for (int i = 1; i < 16; i++) begin
      do_lookup(pg(i));
      chk("R7 no duplicate slot used", 64'(g_hit), 64'd1);
    end
  endtask

  task automatic t_round_robin();
    do_flush();
    for (int i = 0; i < 16; i++) do_fill(pg(20 + i), PA_W'(20 + i) << 12, 0, 3'b000);
    do_fill(pg(36), PA_W'(36) << 12, 0, 3'b000);
    do_lookup(pg(20));
    chk("R6 first victim", 64'(g_hit), 64'd0);
    do_lookup(pg(36));
    chk("R6 new entry", 64'(g_hit), 64'd1);
    do_lookup(pg(21));
    chk("R6 second still present", 64'(g_hit), 64'd1);
    do_fill(pg(37), PA_W'(37) << 12, 0, 3'b000);
    do_lookup(pg(21));
    chk("R6 second victim", 64'(g_hit), 64'd0);
    do_lookup(pg(22));
    chk("R6 third kept", 64'(g_hit), 64'd1);
  endtask

  task automatic t_absorb();
    do_flush();
    do_fill(48'h0000_00a0_1000, 40'h00_0001_1000, 0, 3'b000);
    do_fill(48'h0000_00a1_f000, 40'h00_0001_2000, 0, 3'b000);
    do_fill(48'h0000_00a0_0000, 40'h00_00c0_0000, 1, 3'b010);
    do_lookup(48'h0000_00a0_1008);
    chk("R8 absorbed a", 64'(g_pa), 64'h00_00c0_1008);
    do_lookup(48'h0000_00a1_f008);
    chk("R8 absorbed b", 64'(g_pa), 64'h00_00c1_f008);
    for (int i = 0; i < 15; i++) do_fill(pg(50 + i), PA_W'(50 + i) << 12, 0, 3'b000);
    do_lookup(48'h0000_00a0_0000);
    chk("R8 freed slots reused", 64'(g_hit), 64'd1);
    do_lookup(pg(50));
    chk("R8 fill after absorb", 64'(g_hit), 64'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_small();
    t_huge();
    t_backpressure();
    t_inv_page();
    t_flush();
    t_inv_blocks_fill();
    t_refill();
    t_round_robin();
    t_absorb();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule